// File: doc/BRIEF.md
# Indexed Indirect Word Read Bridge

This block fetches a run of 32-bit words from a wide physical address space. The only path to that space is a three-register window on a simple register bus: a low index register, a high index register and a data register. A request gives a byte address, a byte count and a one-cycle start pulse. For each word, the bridge writes the two index registers and then reads the data register. The word returned by that read goes out on a valid-tagged stream. The bridge then steps to the next word address.

The low index write always has its top bit set. This bit acts as an access-enable flag. The high index write carries the address shifted right by 31. Bit 31 of the word address therefore reaches the window twice: once hidden under the flag in the low write, and once as bit 0 of the high write. The register bus issues one transaction at a time. Each transaction holds until the responder acknowledges it.

Two kinds of request finish without touching the bus. A request with a misaligned address or byte count ends with a one-cycle error pulse. A request with a zero byte count ends with a one-cycle done pulse.

Top module: `idx_rd_bridge`

## Requirements
- R1: For each word, the first bus transaction is a write to register offset 0 (low index). Its data is bits 31:0 of the word address with bit 31 forced to 1.
- R2: The second transaction for each word is a write to offset 1 (high index). Its data is the word address shifted right by 31, zero-extended to 32 bits.
- R3: The third transaction for each word is a read of offset 2 (data). `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` hold steady until the cycle in which `bus_ack_i` is high. No other transactions occur.
- R4: One cycle after the acknowledged data read, `word_valid_o` is high for one cycle and `word_data_o` equals the `bus_rdata_i` value seen with that acknowledge.
- R5: The word address starts at `addr_i` and rises by 4 for each word. Exactly `len_i/4` words are transferred.
- R6: If `addr_i[1:0]` or `len_i[1:0]` is nonzero at start, `err_o` pulses once on the next cycle. No bus transaction and no done pulse follow.
- R7: A start with `len_i` equal to 0 gives a `done_o` pulse on the next cycle and no bus transaction.
- R8: For a nonzero request, `done_o` pulses once, in the same cycle as the last `word_valid_o`.
- R9: A start pulse while `busy_o` is high is ignored. The running request finishes unchanged and no further transactions follow.
- R10: During reset, `busy_o`, `bus_req_o`, `word_valid_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| addr_i | input | ADDR_W | Start byte address |
| len_i | input | CNT_W | Byte count |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request completed pulse |
| err_o | output | 1 | Misaligned request pulse |
| bus_req_o | output | 1 | Register bus transaction valid |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | REG_AW | Register offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| word_valid_o | output | 1 | Output word valid |
| word_data_o | output | 32 | Output word |

## Verification
Delivery of the final word and the completion pulse fall in the same cycle. Every multi-word request therefore provokes this overlap, and requests are run at acknowledge latencies of zero to three cycles. The bench samples both outputs at the falling edge. It judges the overlap correct only when `done_o` is seen together with `word_valid_o` and the word count is already complete. A second start pulse issued mid-request provokes a collision between a new start and a live sequence. It is judged by the exact transaction log that follows.

// File: rtl/idx_rd_pkg.sv
package idx_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_RD   = 2'd3
  } phase_e;
endpackage

// File: rtl/idx_rd_seq.sv
module idx_rd_seq
  import idx_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output phase_e            state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_data_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned STEP = DATA_W / 8;
  localparam int unsigned AL   = $clog2(STEP);

  phase_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q, done_q, err_q;
  logic [DATA_W-1:0] data_q;
  logic              misalign, last;

  assign misalign = (|addr_i[AL-1:0]) | (|len_i[AL-1:0]);
  assign last     = (cnt_q == CNT_W'(STEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (misalign)         err_q  <= 1'b1;
          else if (len_i == '0) done_q <= 1'b1;
          else begin
            state_q <= ST_LO;
            addr_q  <= addr_i;
            cnt_q   <= len_i;
          end
        end
        ST_LO: if (ack_i) state_q <= ST_HI;
        ST_HI: if (ack_i) state_q <= ST_RD;
        ST_RD: if (ack_i) begin
          valid_q <= 1'b1;
          data_q  <= rdata_i;
          if (last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_LO;
            addr_q  <= addr_q + ADDR_W'(STEP);
            cnt_q   <= cnt_q - CNT_W'(STEP);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign addr_o       = addr_q;
  assign word_valid_o = valid_q;
  assign word_data_o  = data_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/idx_rd_bus.sv
module idx_rd_bus
  import idx_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 8,
  parameter int unsigned LO_OFF  = 0,
  parameter int unsigned HI_OFF  = 1,
  parameter int unsigned DAT_OFF = 2
) (
  input  phase_e            state_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_o,
  output logic              we_o,
  output logic [REG_AW-1:0] raddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [DATA_W-1:0] EN_BIT = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] lo_word, hi_word;
  assign lo_word = addr_i[DATA_W-1:0] | EN_BIT;
  assign hi_word = DATA_W'(addr_i >> (DATA_W - 1));

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b1;
    raddr_o = REG_AW'(LO_OFF);
    wdata_o = lo_word;
    case (state_i)
      ST_LO: ;
      ST_HI: begin
        raddr_o = REG_AW'(HI_OFF);
        wdata_o = hi_word;
      end
      ST_RD: begin
        we_o    = 1'b0;
        raddr_o = REG_AW'(DAT_OFF);
        wdata_o = '0;
      end
      default: begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        wdata_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/idx_rd_bridge.sv
module idx_rd_bridge
  import idx_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REG_AW  = 8,
  parameter int unsigned LO_OFF  = 0,
  parameter int unsigned HI_OFF  = 1,
  parameter int unsigned DAT_OFF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [REG_AW-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              word_valid_o,
  output logic [31:0]       word_data_o
);
  localparam int unsigned DATA_W = 32;

  phase_e            state;
  logic [ADDR_W-1:0] waddr;

  idx_rd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .len_i        (len_i),
    .ack_i        (bus_ack_i),
    .rdata_i      (bus_rdata_i),
    .state_o      (state),
    .addr_o       (waddr),
    .word_valid_o (word_valid_o),
    .word_data_o  (word_data_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  idx_rd_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW),
    .LO_OFF(LO_OFF), .HI_OFF(HI_OFF), .DAT_OFF(DAT_OFF)
  ) u_bus (
    .state_i (state),
    .addr_i  (waddr),
    .req_o   (bus_req_o),
    .we_o    (bus_we_o),
    .raddr_o (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/idx_rd_chk.sv
module idx_rd_chk #(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned LO_OFF = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [REG_AW-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ack_i,
  input logic              word_valid_o
);
  // R3
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o));

  // R1
  lo_enable_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == REG_AW'(LO_OFF) |-> bus_wdata_o[31]);

  // R4
  word_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(bus_req_o && !bus_we_o && bus_ack_i));

  // R6
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_req_o && !done_o && !word_valid_o);

  // R8
  done_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(busy_o) |-> word_valid_o);

  // R7
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(busy_o) |-> !bus_req_o && !word_valid_o);
endmodule

bind idx_rd_bridge idx_rd_chk #(.REG_AW(REG_AW), .LO_OFF(LO_OFF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i),
  .word_valid_o (word_valid_o)
);

// File: tb/sim_idx_rd_bridge.sv
module sim_idx_rd_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int CW = 16;
  localparam int NV = 5;

  localparam logic [AW-1:0] V_ADDR [NV] = '{48'h0000_0000_1000, 48'h0000_7FFF_FFF8,
                                            48'hABCD_FFFF_FFFC, 48'h0012_3456_7890,
                                            48'h0001_8000_0000};
  localparam logic [CW-1:0] V_LEN  [NV] = '{16'd8, 16'd16, 16'd8, 16'd4, 16'd12};
  localparam int            V_LAT  [NV] = '{0, 1, 3, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] len = '0;
  logic busy, done, err, req, we, ack = 1'b0, wvalid;
  logic [7:0] baddr;
  logic [31:0] wdata, rdata = '0, wdat;

  int checks = 0, fails = 0, lat = 0, wc = 0;
  logic [31:0] reg_lo = '0, reg_hi = '0;
  int n = 0, k = 0;
  bit done_seen = 0, err_seen = 0, done_w = 0;
  logic        tr_we [64];
  logic [7:0]  tr_a  [64];
  logic [31:0] tr_d  [64];
  logic [31:0] w     [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_rd_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .busy_o(busy), .done_o(done), .err_o(err),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(baddr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata),
    .word_valid_o(wvalid), .word_data_o(wdat)
  );

  function automatic logic [31:0] mdl(logic [AW-1:0] a);
    return a[31:0] ^ {a[47:32], a[15:0]} ^ 32'h3C5A_96E1;
  endfunction

  // register window model: address rebuilt from both index registers
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; wc <= 0;
    end else if (ack) begin
      ack <= 1'b0;
      if (we && baddr == 8'd0) reg_lo <= wdata;
      if (we && baddr == 8'd1) reg_hi <= wdata;
    end else if (req) begin
      if (wc >= lat) begin
        ack <= 1'b1; wc <= 0;
        rdata <= mdl({reg_hi[16:0], reg_lo[30:0]});
      end else wc <= wc + 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (req && ack && n < 64) begin
      tr_we[n] = we; tr_a[n] = baddr; tr_d[n] = wdata; n = n + 1;
    end
    if (wvalid && k < 64) begin w[k] = wdat; k = k + 1; end
    if (done) begin done_seen = 1; done_w = wvalid; end
    if (err) err_seen = 1;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n = 0; k = 0; done_seen = 0; err_seen = 0; done_w = 0;
  endtask

  task automatic issue(logic [AW-1:0] a, logic [CW-1:0] l);
    @(negedge clk); addr = a; len = l; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000 && !done_seen && !err_seen; i++) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_run(logic [AW-1:0] a, logic [CW-1:0] l);
    int words = int'(l) / 4;
    chk(done_seen && !err_seen, "R5 completion", {62'd0, done_seen, err_seen}, 64'h2);
    chk(n == 3 * words, "R3 transaction count", n, 3 * words);
    chk(k == words, "R5 word count", k, words);
    chk(done_w, "R8 done with last word", done_w, 1);
    for (int i = 0; i < words && 3 * i + 2 < n && i < k; i++) begin
      logic [AW-1:0] ea = a + AW'(4 * i);
      logic [31:0] elo = ea[31:0] | 32'h8000_0000;
      logic [31:0] ehi = 32'(ea >> 31);
      chk(tr_we[3*i] && tr_a[3*i] == 8'd0 && tr_d[3*i] == elo, "R1 low index write",
          {tr_we[3*i], tr_a[3*i], tr_d[3*i]}, {1'b1, 8'd0, elo});
      chk(tr_we[3*i+1] && tr_a[3*i+1] == 8'd1 && tr_d[3*i+1] == ehi, "R2 high index write",
          {tr_we[3*i+1], tr_a[3*i+1], tr_d[3*i+1]}, {1'b1, 8'd1, ehi});
      chk(!tr_we[3*i+2] && tr_a[3*i+2] == 8'd2, "R3 data read",
          {tr_we[3*i+2], tr_a[3*i+2]}, {1'b0, 8'd2});
      chk(w[i] == mdl(ea), "R4 word data", w[i], mdl(ea));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk({busy, req, wvalid, done, err} == 5'b0, "R10 reset outputs",
        {busy, req, wvalid, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clr(); lat = V_LAT[v];
      issue(V_ADDR[v], V_LEN[v]);
      wait_end();
      check_run(V_ADDR[v], V_LEN[v]);
    end

    // R7 zero length
    clr(); lat = 0;
    issue(48'h100, 16'd0);
    wait_end();
    chk(done_seen && !err_seen, "R7 zero length done", done_seen, 1);
    chk(n == 0 && k == 0, "R7 no bus traffic", n, 0);

    // R6 misaligned address, then misaligned count
    clr();
    issue(48'h102, 16'd8);
    wait_end();
    chk(err_seen && !done_seen, "R6 misaligned address", {err_seen, done_seen}, 2'b10);
    chk(n == 0, "R6 no bus traffic", n, 0);
    clr();
    issue(48'h100, 16'd6);
    wait_end();
    chk(err_seen && !done_seen, "R6 misaligned count", {err_seen, done_seen}, 2'b10);
    chk(n == 0 && k == 0, "R6 no traffic on count error", n, 0);

    // R9 start while busy
    clr(); lat = 2;
    issue(48'h0000_0000_2000, 16'd8);
    repeat (3) @(negedge clk);
    chk(busy, "R9 busy before second start", busy, 1);
    issue(48'h0000_0000_9000, 16'd4);
    wait_end();
    check_run(48'h0000_0000_2000, 16'd8);
    repeat (20) @(negedge clk);
    chk(n == 6 && k == 2, "R9 second start ignored", n, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule